// File: doc/BRIEF.md
# PPS Negotiation Responder

This block answers the protocol parameter selection exchange that a smart card reader may start right after the answer-to-reset. While the surrounding card logic waits for a command header (signalled by `cmd_idle`), a received byte of 0xFF is taken as the start of such an exchange instead. The block then takes the rest of the request from the reader byte by byte, stores it and checks its check byte. If the request is valid, it sends the request back unchanged as its response, one byte per transmit handshake.

The request is the start byte, a format byte, up to three optional parameter bytes and a closing check byte. Bits 4, 5 and 6 of the format byte say which optional bytes are present. Absent bytes are skipped, both while receiving and while answering. When the first optional byte goes out in the response, its two nibbles become the new clock-rate and baud-rate adjustment indices. These indices are applied, with a one-cycle update strobe, only once the response check byte has been sent. Then `busy` drops and control goes back to the command-wait logic. Computing the rate ratio from the indices, and the bit timing of the serial line, are handled elsewhere.

Top module: `pps_responder`

## Requirements
- R1: While idle, a received byte of 0xFF with `cmd_idle` high starts an exchange: `busy` rises on the next cycle and `pps_count` rises by one, wrapping at its width. Any other byte, or any byte while `cmd_idle` is low, leaves `busy` and `pps_count` unchanged.
- R2: After the start byte the block expects the format byte. Then it takes the first optional byte only if format bit 4 is set, the second only if bit 5 is set, and the third only if bit 6 is set. The check byte comes last.
- R3: The XOR of all received request bytes, the check byte included, must be zero. If it is not, `busy` drops on the cycle after the check byte, no byte is offered on the transmit side and `rate_upd` stays low.
- R4: After a valid request, the response repeats the received bytes in their received order, so absent optional bytes are also absent from the response.
- R5: A response byte is transferred on a clock edge where `tx_valid` and `tx_ready` are both high. While `tx_ready` is low, `tx_valid` stays high and `tx_byte` holds its value.
- R6: When the first optional byte is present, the new `fi_out` is its bits 7:4 and the new `di_out` is its bits 3:0. When it is absent, both indices keep their previous values.
- R7: On the cycle after the response check byte is transferred, `rate_upd` is high for exactly one cycle, `fi_out` and `di_out` show the new values and `busy` is low. The indices change at no other time.
- R8: Bytes received while the response is being sent are ignored and do not alter the response.
- R9: After reset, `busy`, `tx_valid`, `rate_upd` and `pps_count` are zero, `fi_out` is `FI_RST` (default 1) and `di_out` is `DI_RST` (default 1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_idle | input | 1 | High while the card logic waits for a command header |
| rx_valid | input | 1 | A byte from the reader is present on `rx_byte` this cycle |
| rx_byte | input | 8 | Received byte |
| tx_valid | output | 1 | A response byte is offered on `tx_byte` |
| tx_ready | input | 1 | Transmitter accepts the offered byte |
| tx_byte | output | 8 | Response byte |
| busy | output | 1 | Exchange in progress; the block owns the line |
| fi_out | output | 4 | Clock-rate adjustment index in force |
| di_out | output | 4 | Baud-rate adjustment index in force |
| rate_upd | output | 1 | One-cycle strobe: new indices are valid |
| pps_count | output | CNT_W | Exchanges started since reset |

## Verification
The main function is tried with four request shapes: no optional bytes, only the first, only the second, and all three. This tells apart a sequencer that decodes each presence bit on its own from one that stops at the first clear bit or reads the wrong bit. The only-the-second case also shows that indices are kept when the first optional byte is absent. A request with a wrong check byte separates checksum rejection from blind echoing. A response with `tx_ready` held low, and reader bytes injected during the response, show that the handshake holds its byte and that the stored request is frozen. Non-0xFF bytes and 0xFF with `cmd_idle` low show that the start condition needs both.

// File: rtl/pps_pkg.sv
// Shared types for the PPS responder: byte positions, phases and the
// presence-driven successor function. Assumes one byte per position.
package pps_pkg;

    localparam int unsigned IDX_W   = 3;
    localparam int unsigned NBYTES  = 6;
    localparam int unsigned BIT_OPT1 = 4;
    localparam int unsigned BIT_OPT2 = 5;
    localparam int unsigned BIT_OPT3 = 6;
    localparam logic [7:0]  START_BYTE = 8'hFF;

    // Position order is the wire order and must not be changed.
    typedef enum logic [IDX_W-1:0] {
        POS_START = 3'd0,
        POS_FMT   = 3'd1,
        POS_OPT1  = 3'd2,
        POS_OPT2  = 3'd3,
        POS_OPT3  = 3'd4,
        POS_CHK   = 3'd5
    } pps_pos_e;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_REQ  = 2'd1,
        PH_RSP  = 2'd2
    } pps_phase_e;

    // Next position after cur, skipping optional bytes whose presence bit is clear.
    function automatic pps_pos_e pps_next(input pps_pos_e cur, input logic [7:0] fmt);
        pps_pos_e nxt;
        case (cur)
            POS_START: nxt = POS_FMT;
            POS_FMT:   nxt = fmt[BIT_OPT1] ? POS_OPT1 :
                             fmt[BIT_OPT2] ? POS_OPT2 :
                             fmt[BIT_OPT3] ? POS_OPT3 : POS_CHK;
            POS_OPT1:  nxt = fmt[BIT_OPT2] ? POS_OPT2 :
                             fmt[BIT_OPT3] ? POS_OPT3 : POS_CHK;
            POS_OPT2:  nxt = fmt[BIT_OPT3] ? POS_OPT3 : POS_CHK;
            default:   nxt = POS_CHK;
        endcase
        return nxt;
    endfunction

endpackage

// File: rtl/pps_seq.sv
// Sequencer for the PPS exchange: idle, request intake, response output.
// Assumes rx_valid is a single-cycle qualifier per byte and that the
// buffer supplies the stored format byte and the running checksum test.
module pps_seq
    import pps_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_idle,
    input  logic       rx_valid,
    input  logic [7:0] rx_byte,
    input  logic       tx_ready,
    input  logic [7:0] fmt_stored,
    input  logic       sum_zero,
    output pps_phase_e phase,
    output pps_pos_e   pos,
    output logic       wr_en,
    output logic       wr_first,
    output logic       start,
    output logic       tx_valid,
    output logic       capture,
    output logic       commit
);

    pps_phase_e phase_nxt;
    pps_pos_e   pos_nxt;
    logic [7:0] fmt_eff;

    // Format byte in effect: the arriving byte when it is the format byte itself.
    always_comb fmt_eff = (phase == PH_REQ && pos == POS_FMT) ? rx_byte : fmt_stored;

    // Next-state and strobe decode for all three phases.
    always_comb begin
        phase_nxt = phase;
        pos_nxt   = pos;
        wr_en     = 1'b0;
        wr_first  = 1'b0;
        start     = 1'b0;
        tx_valid  = 1'b0;
        capture   = 1'b0;
        commit    = 1'b0;
        case (phase)
            PH_IDLE: begin
                if (cmd_idle && rx_valid && rx_byte == START_BYTE) begin
                    wr_en     = 1'b1;
                    wr_first  = 1'b1;
                    start     = 1'b1;
                    phase_nxt = PH_REQ;
                    pos_nxt   = POS_FMT;
                end
            end
            PH_REQ: begin
                if (rx_valid) begin
                    wr_en = 1'b1;
                    if (pos == POS_CHK) begin
                        phase_nxt = sum_zero ? PH_RSP : PH_IDLE;
                        pos_nxt   = POS_START;
                    end else begin
                        pos_nxt = pps_next(pos, fmt_eff);
                    end
                end
            end
            PH_RSP: begin
                tx_valid = 1'b1;
                if (tx_ready) begin
                    capture = (pos == POS_OPT1);
                    if (pos == POS_CHK) begin
                        commit    = 1'b1;
                        phase_nxt = PH_IDLE;
                        pos_nxt   = POS_START;
                    end else begin
                        pos_nxt = pps_next(pos, fmt_stored);
                    end
                end
            end
            default: begin
                phase_nxt = PH_IDLE;
                pos_nxt   = POS_START;
            end
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
            pos   <= POS_START;
        end else begin
            phase <= phase_nxt;
            pos   <= pos_nxt;
        end
    end

endmodule

// File: rtl/pps_store.sv
// Byte store for the request, read back as the response, plus the running
// XOR of the request. Assumes write and read never target one cycle together.
module pps_store
    import pps_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_first,
    input  logic [IDX_W-1:0] wr_pos,
    input  logic [7:0]       wr_byte,
    input  logic [IDX_W-1:0] rd_pos,
    output logic [7:0]       rd_byte,
    output logic [7:0]       fmt_byte,
    output logic             sum_zero
);

    logic [7:0] mem [NBYTES];
    logic [7:0] acc;

    // One register per byte position.
    for (genvar g = 0; g < NBYTES; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n)
                mem[g] <= '0;
            else if (wr_en && wr_pos == IDX_W'(g))
                mem[g] <= wr_byte;
        end
    end

    // Running XOR, restarted by the start byte.
    always_ff @(posedge clk) begin
        if (!rst_n)
            acc <= '0;
        else if (wr_en)
            acc <= (wr_first ? 8'h00 : acc) ^ wr_byte;
    end

    // Read port and checksum test on the arriving byte.
    always_comb begin
        rd_byte  = (int'(rd_pos) < NBYTES) ? mem[rd_pos] : 8'h00;
        fmt_byte = mem[POS_FMT];
        sum_zero = ((acc ^ wr_byte) == 8'h00);
    end

endmodule

// File: rtl/pps_rate.sv
// Holds the rate indices in force. A value captured from the response's
// first optional byte is held pending and applied only on commit.
module pps_rate #(
    parameter logic [3:0] FI_RST = 4'd1,
    parameter logic [3:0] DI_RST = 4'd1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       capture,
    input  logic [7:0] cap_byte,
    input  logic       commit,
    output logic [3:0] fi,
    output logic [3:0] di,
    output logic       upd
);

    logic [3:0] pend_fi;
    logic [3:0] pend_di;
    logic       pend_vld;

    // Pending capture, cleared once applied.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_fi  <= FI_RST;
            pend_di  <= DI_RST;
            pend_vld <= 1'b0;
        end else if (capture) begin
            pend_fi  <= cap_byte[7:4];
            pend_di  <= cap_byte[3:0];
            pend_vld <= 1'b1;
        end else if (commit) begin
            pend_vld <= 1'b0;
        end
    end

    // Indices in force and the update strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fi  <= FI_RST;
            di  <= DI_RST;
            upd <= 1'b0;
        end else begin
            upd <= commit;
            if (commit && pend_vld) begin
                fi <= pend_fi;
                di <= pend_di;
            end
        end
    end

endmodule

// File: rtl/pps_responder.sv
// Top of the PPS responder. Takes a request after a 0xFF start byte seen
// during command wait, checks it, echoes it and applies the new indices.
// Assumes the caller stops interpreting reader bytes while busy is high.
module pps_responder
    import pps_pkg::*;
#(
    parameter int unsigned CNT_W  = 8,
    parameter logic [3:0]  FI_RST = 4'd1,
    parameter logic [3:0]  DI_RST = 4'd1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_idle,
    input  logic             rx_valid,
    input  logic [7:0]       rx_byte,
    output logic             tx_valid,
    input  logic             tx_ready,
    output logic [7:0]       tx_byte,
    output logic             busy,
    output logic [3:0]       fi_out,
    output logic [3:0]       di_out,
    output logic             rate_upd,
    output logic [CNT_W-1:0] pps_count
);

    pps_phase_e phase;
    pps_pos_e   pos;
    logic       wr_en, wr_first, start, capture, commit, sum_zero;
    logic [7:0] fmt_byte;

    pps_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_idle   (cmd_idle),
        .rx_valid   (rx_valid),
        .rx_byte    (rx_byte),
        .tx_ready   (tx_ready),
        .fmt_stored (fmt_byte),
        .sum_zero   (sum_zero),
        .phase      (phase),
        .pos        (pos),
        .wr_en      (wr_en),
        .wr_first   (wr_first),
        .start      (start),
        .tx_valid   (tx_valid),
        .capture    (capture),
        .commit     (commit)
    );

    pps_store u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_first (wr_first),
        .wr_pos   (pos),
        .wr_byte  (rx_byte),
        .rd_pos   (pos),
        .rd_byte  (tx_byte),
        .fmt_byte (fmt_byte),
        .sum_zero (sum_zero)
    );

    pps_rate #(.FI_RST(FI_RST), .DI_RST(DI_RST)) u_rate (
        .clk      (clk),
        .rst_n    (rst_n),
        .capture  (capture),
        .cap_byte (tx_byte),
        .commit   (commit),
        .fi       (fi_out),
        .di       (di_out),
        .upd      (rate_upd)
    );

    // Exchange counter, wraps at its width.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pps_count <= '0;
        else if (start)
            pps_count <= pps_count + 1'b1;
    end

    // Ownership flag for the surrounding logic.
    always_comb busy = (phase != PH_IDLE);

endmodule

// File: rtl/pps_responder_chk.sv
// Property checker for pps_responder, attached by bind. Observes ports only.
module pps_responder_chk #(
    parameter int unsigned CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_idle,
    input logic             rx_valid,
    input logic [7:0]       rx_byte,
    input logic             tx_valid,
    input logic             tx_ready,
    input logic [7:0]       tx_byte,
    input logic             busy,
    input logic [3:0]       fi_out,
    input logic [3:0]       di_out,
    input logic             rate_upd,
    input logic [CNT_W-1:0] pps_count
);

    // R5: an offered byte is held until taken.
    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && !tx_ready |=> tx_valid && $stable(tx_byte));

    // R7: the update strobe lasts one cycle.
    a_r7_one_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rate_upd |=> !rate_upd);

    // R7: the strobe follows a completed transfer and coincides with release.
    a_r7_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        rate_upd |-> !busy && $past(tx_valid && tx_ready));

    // R7: indices move only together with the strobe.
    a_r7_idx_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !rate_upd |-> $stable(fi_out) && $stable(di_out));

    // R1: each new exchange bumps the counter by one.
    a_r1_count: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> pps_count == CNT_W'($past(pps_count) + 1'b1));

    // R1: the counter is untouched while no exchange starts.
    a_r1_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !$rose(busy) |-> $stable(pps_count));

    // R3: nothing is offered outside an exchange.
    a_r3_no_tx_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !tx_valid);

    // R1: cmd_idle, rx_valid and rx_byte feed the start check; kept observed here.
    a_r1_start_needs_ff: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(cmd_idle && rx_valid && rx_byte == 8'hFF));

endmodule

bind pps_responder pps_responder_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/pps_responder_tb.sv
// Directed bench for pps_responder: one task per scenario.
module pps_responder_tb;

    localparam int CNT_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cmd_idle = 1'b0;
    logic             rx_valid = 1'b0;
    logic [7:0]       rx_byte = 8'h00;
    logic             tx_valid;
    logic             tx_ready = 1'b0;
    logic [7:0]       tx_byte;
    logic             busy;
    logic [3:0]       fi_out;
    logic [3:0]       di_out;
    logic             rate_upd;
    logic [CNT_W-1:0] pps_count;

    int checks = 0;
    int errors = 0;

    logic [7:0] req [6];
    int         nreq;
    logic [7:0] got [8];
    int         ngot;
    int         nupd;
    logic [3:0] exp_fi = 4'd1;
    logic [3:0] exp_di = 4'd1;
    logic [CNT_W-1:0] exp_cnt = '0;

    always #10 clk = ~clk;

    pps_responder #(.CNT_W(CNT_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_idle(cmd_idle), .rx_valid(rx_valid),
        .rx_byte(rx_byte), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .tx_byte(tx_byte), .busy(busy), .fi_out(fi_out), .di_out(di_out),
        .rate_upd(rate_upd), .pps_count(pps_count)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Builds a request from a format byte and optional values; fills the check byte.
    task automatic build(input logic [7:0] fmt, input logic [7:0] o1,
                         input logic [7:0] o2, input logic [7:0] o3, input bit bad);
        logic [7:0] x;
        nreq = 0;
        req[nreq++] = 8'hFF;
        req[nreq++] = fmt;
        if (fmt[4]) req[nreq++] = o1;
        if (fmt[5]) req[nreq++] = o2;
        if (fmt[6]) req[nreq++] = o3;
        x = 8'h00;
        for (int i = 0; i < nreq; i++) x ^= req[i];
        req[nreq++] = bad ? ~x : x;
        if (fmt[4] && !bad) begin
            exp_fi = o1[7:4];
            exp_di = o1[3:0];
        end
    endtask

    task automatic send_req();
        cmd_idle = 1'b1;
        for (int i = 0; i < nreq; i++) begin
            @(negedge clk);
            rx_valid = 1'b1;
            rx_byte  = req[i];
        end
        @(negedge clk);
        rx_valid = 1'b0;
        cmd_idle = 1'b0;
    endtask

    // Collects the response; optional stall and injected reader bytes.
    task automatic take_resp(input bit stall, input bit inject);
        logic [7:0] held;
        ngot = 0;
        nupd = 0;
        for (int cyc = 0; cyc < 40; cyc++) begin
            @(negedge clk);
            if (rate_upd) nupd++;
            if (!busy) break;
            rx_valid = inject;
            rx_byte  = 8'h55;
            if (stall && cyc == 2) begin
                tx_ready = 1'b0;
                held = tx_byte;
                repeat (3) @(negedge clk);
                check(tx_valid && tx_byte == held, "R5 held byte while stalled", tx_byte, held);
            end
            tx_ready = 1'b1;
            if (tx_valid && ngot < 8) got[ngot++] = tx_byte;
        end
        tx_ready = 1'b0;
        rx_valid = 1'b0;
    endtask

    task automatic compare_resp(input string tag);
        check(ngot == nreq, {tag, " response length"}, ngot, nreq);
        for (int i = 0; i < nreq && i < ngot; i++)
            check(got[i] == req[i], {tag, " response byte"}, got[i], req[i]);
        check(nupd == 1, "R7 one strobe", nupd, 1);
        check(fi_out == exp_fi && di_out == exp_di, "R6 indices", {fi_out, di_out}, {exp_fi, exp_di});
        check(!busy, "R7 released", busy, 0);
        exp_cnt++;
        check(pps_count == exp_cnt, "R1 count", pps_count, exp_cnt);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(!busy && !tx_valid && !rate_upd, "R9 idle outputs", {busy, tx_valid, rate_upd}, 0);
        check(fi_out == 4'd1 && di_out == 4'd1, "R9 indices", {fi_out, di_out}, 8'h11);
        check(pps_count == '0, "R9 count", pps_count, 0);
    endtask

    task automatic t_minimal();
        build(8'h00, 8'h00, 8'h00, 8'h00, 1'b0);
        send_req();
        take_resp(1'b0, 1'b0);
        compare_resp("R2 R4 minimal");
    endtask

    task automatic t_opt1();
        build(8'h10, 8'h96, 8'h00, 8'h00, 1'b0);
        send_req();
        take_resp(1'b0, 1'b0);
        compare_resp("R2 R4 R6 first-only");
    endtask

    task automatic t_opt2_only();
        build(8'h20, 8'h00, 8'hAB, 8'h00, 1'b0);
        send_req();
        take_resp(1'b0, 1'b0);
        compare_resp("R2 R4 R6 second-only");
    endtask

    task automatic t_all_stall_inject();
        build(8'h70, 8'h11, 8'h22, 8'h33, 1'b0);
        send_req();
        take_resp(1'b1, 1'b1);
        compare_resp("R2 R4 R5 R8 all-present");
    endtask

    task automatic t_bad_sum();
        int seen;
        seen = 0;
        build(8'h10, 8'h45, 8'h00, 8'h00, 1'b1);
        send_req();
        check(!busy, "R3 released after bad check byte", busy, 0);
        tx_ready = 1'b1;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            if (tx_valid || rate_upd) seen++;
        end
        tx_ready = 1'b0;
        check(seen == 0, "R3 no response no strobe", seen, 0);
        check(fi_out == exp_fi && di_out == exp_di, "R3 indices kept", {fi_out, di_out}, {exp_fi, exp_di});
        exp_cnt++;
        check(pps_count == exp_cnt, "R1 count on rejected exchange", pps_count, exp_cnt);
    endtask

    task automatic t_no_start();
        cmd_idle = 1'b1;
        @(negedge clk); rx_valid = 1'b1; rx_byte = 8'h00;
        @(negedge clk); rx_valid = 1'b1; rx_byte = 8'hA4;
        @(negedge clk); rx_valid = 1'b0;
        check(!busy && pps_count == exp_cnt, "R1 non-FF ignored", pps_count, exp_cnt);
        cmd_idle = 1'b0;
        @(negedge clk); rx_valid = 1'b1; rx_byte = 8'hFF;
        @(negedge clk); rx_valid = 1'b0;
        @(negedge clk);
        check(!busy && pps_count == exp_cnt, "R1 FF without cmd_idle ignored", pps_count, exp_cnt);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_no_start();
        t_minimal();
        t_opt1();
        t_opt2_only();
        t_bad_sum();
        t_all_stall_inject();
        repeat (3) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule